// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block is the byte-merge datapath behind the left and right partial-word load and store operations on big-endian words. An effective address whose low bits point anywhere inside a word is reduced to the word-aligned address, which is then used for the memory access. For a load, the memory word read at that address is shifted and folded into the old destination register value. For a store, the register value is shifted and folded into the word already in memory, and the result is the word to write back.

The unit is purely combinational. The merged word, the aligned address and a segment error flag all follow the inputs in the same cycle. By default it works on 32-bit words with a two-bit byte offset. A parameter switches it to 64-bit words with a three-bit offset, where the left forms shift by (7 − offset) bytes. Address generation, the memory access itself and every fault other than the segment check belong to the surrounding pipeline.

Top module: `uwm_merge_unit`

## Requirements
- R1: The two-bit operation code selects the variant: 2'b00 load-left, 2'b01 load-right, 2'b10 store-left, 2'b11 store-right. Bit 1 set means store, and bit 0 set means a right form.
- R2: `aligned_addr_o` equals `addr_i` with its low offset bits forced to zero (two bits for 32-bit words, three for 64-bit words). All other bits pass through unchanged.
- R3: `addr_err_o` equals the most significant address bit. No other address value, including any misaligned offset, raises it.
- R4: Load-left with byte offset k and N bytes per word: the result is the memory word shifted left by (N−1−k)×8 bits, with the register supplying every bit below that shift.
- R5: Load-right with byte offset k: the result is the memory word shifted right by k×8 bits. The register supplies the high bits that an all-ones word shifted right by k×8 does not cover.
- R6: Store-left with byte offset k: the result is the register value shifted right by (N−1−k)×8 bits. The memory word supplies the bits outside an all-ones word shifted right by the same amount.
- R7: Store-right with byte offset k: the result is the register value shifted left by k×8 bits. The memory word supplies the bits outside an all-ones word shifted left by k×8.
- R8: At offset 0, load-right replaces the whole register with the memory word. Load-left at offset 0 places only the lowest memory byte into the top byte and keeps the other register bytes.
- R9: When the shift is zero (left forms at offset N−1, right forms at offset 0), the result is the full source word: memory for loads, register for stores.
- R10: With `WIDE` set, words are 64 bits, the offset is the low three address bits, and the R4–R9 rules apply with N = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation code (R1) |
| addr_i | input | ADDR_W | Effective byte address |
| mem_word_i | input | DW | Word read at the aligned address |
| reg_word_i | input | DW | Register value (old destination or store data) |
| merged_o | output | DW | Merged register (loads) or write-back word (stores) |
| aligned_addr_o | output | ADDR_W | Word-aligned access address |
| addr_err_o | output | 1 | Segment error: top address bit set |

## Verification
The bench builds two instances side by side. One uses the defaults (`WIDE`=0, `ADDR_W`=32), where all four byte offsets of every operation are reachable. The other uses `WIDE`=1 with `ADDR_W`=64, which brings in the eight offsets of the wide variant and the 56-bit shifts its left forms need at offset 0. On both instances, the zero-shift and single-byte extremes are covered by directed cases, and a seeded random sweep is compared against a shift-and-mask model.

// File: rtl/uwm_pkg.sv
`timescale 1ns/1ps
package uwm_pkg;

    // Operation code: bit 1 = store, bit 0 = right form
    typedef enum logic [1:0] {
        UWM_LD_LEFT  = 2'b00,
        UWM_LD_RIGHT = 2'b01,
        UWM_ST_LEFT  = 2'b10,
        UWM_ST_RIGHT = 2'b11
    } uwm_op_e;

    // Shift plan handed from the decoder to the datapath
    typedef struct packed {
        logic       move_left;   // source moves towards the MSB
        logic       src_is_mem;  // memory word is the moving source
        logic [2:0] lanes;       // shift distance in bytes
    } uwm_plan_t;

    function automatic logic op_is_store(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic op_is_right(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/uwm_plan.sv
`timescale 1ns/1ps
module uwm_plan
    import uwm_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [1:0]       op_i,
    input  logic [OFF_W-1:0] off_i,
    output uwm_plan_t        plan_o
);
    logic [OFF_W-1:0] lane_cnt;

    always_comb begin
        // Left forms shift by (N-1-k) bytes; with N a power of two that is ~k
        lane_cnt = op_is_right(op_i) ? off_i : ~off_i;
        plan_o.lanes      = 3'(lane_cnt);
        // load-left and store-right move their source towards the MSB
        plan_o.move_left  = ~(op_is_store(op_i) ^ op_is_right(op_i));
        plan_o.src_is_mem = ~op_is_store(op_i);
    end
endmodule

// File: rtl/uwm_lane_mask.sv
`timescale 1ns/1ps
module uwm_lane_mask #(
    parameter int DW = 32
) (
    input  logic          move_left_i,
    input  logic [2:0]    lanes_i,
    output logic [DW-1:0] mask_o
);
    localparam int LANES = DW / 8;

    logic [3:0] lane_sh;
    assign lane_sh = {1'b0, lanes_i};

    // A byte lane takes new data when the shifted source covers it
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [3:0] LANE_IDX = 4'(j);
        assign mask_o[j*8 +: 8] = {8{move_left_i ? (LANE_IDX >= lane_sh)
                                                 : (LANE_IDX < (4'(LANES) - lane_sh))}};
    end

    always_comb begin
        if (!$isunknown({move_left_i, lanes_i})) begin
            AST_MASK_WIDTH: assert ($countones(mask_o) == DW - 8 * int'(lanes_i))
                else $error("mask width does not match shift"); // R6
        end
    end
endmodule

// File: rtl/uwm_shifter.sv
`timescale 1ns/1ps
module uwm_shifter #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src_i,
    input  logic          move_left_i,
    input  logic [2:0]    lanes_i,
    output logic [DW-1:0] shifted_o
);
    logic [5:0] sh_bits;

    always_comb begin
        sh_bits   = {lanes_i, 3'b000};
        shifted_o = move_left_i ? (src_i << sh_bits) : (src_i >> sh_bits);
    end
endmodule

// File: rtl/uwm_merge_unit.sv
`timescale 1ns/1ps
module uwm_merge_unit
    import uwm_pkg::*;
#(
    parameter bit WIDE   = 1'b0,
    parameter int ADDR_W = 32,
    localparam int DW    = WIDE ? 64 : 32
) (
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     mem_word_i,
    input  logic [DW-1:0]     reg_word_i,
    output logic [DW-1:0]     merged_o,
    output logic [ADDR_W-1:0] aligned_addr_o,
    output logic              addr_err_o
);
    localparam int OFF_W = WIDE ? 3 : 2;
    localparam int LANES = DW / 8;

    logic [OFF_W-1:0] offset;
    uwm_plan_t        plan;
    logic [DW-1:0]    src_word;
    logic [DW-1:0]    old_word;
    logic [DW-1:0]    shifted;
    logic [DW-1:0]    take_mask;

    assign offset         = addr_i[OFF_W-1:0];
    assign aligned_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign addr_err_o     = addr_i[ADDR_W-1];

    uwm_plan #(.OFF_W(OFF_W)) u_plan (
        .op_i   (op_i),
        .off_i  (offset),
        .plan_o (plan)
    );

    assign src_word = plan.src_is_mem ? mem_word_i : reg_word_i;
    assign old_word = plan.src_is_mem ? reg_word_i : mem_word_i;

    uwm_shifter #(.DW(DW)) u_shift (
        .src_i       (src_word),
        .move_left_i (plan.move_left),
        .lanes_i     (plan.lanes),
        .shifted_o   (shifted)
    );

    uwm_lane_mask #(.DW(DW)) u_mask (
        .move_left_i (plan.move_left),
        .lanes_i     (plan.lanes),
        .mask_o      (take_mask)
    );

    assign merged_o = (shifted & take_mask) | (old_word & ~take_mask);

    always_comb begin
        if (!$isunknown({op_i, addr_i, mem_word_i, reg_word_i})) begin
            if (!op_i[0]) begin
                AST_LEFT_SHIFT: assert (int'(plan.lanes) + int'(offset) == LANES - 1)
                    else $error("left shift distance wrong"); // R4
            end else begin
                AST_RIGHT_SHIFT: assert (int'(plan.lanes) == int'(offset))
                    else $error("right shift distance wrong"); // R5
            end
            AST_KEEP_OLD: assert ((merged_o & ~take_mask) == (old_word & ~take_mask))
                else $error("untouched bits changed"); // R7
            if (plan.lanes == 3'd0) begin
                AST_FULL_REPLACE: assert (merged_o == (op_i[1] ? reg_word_i : mem_word_i))
                    else $error("zero shift not a full replace"); // R9
            end
        end
    end
endmodule

// File: tb/uwm_merge_unit_tb_top.sv
`timescale 1ns/1ps
module uwm_merge_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // narrow instance
    logic [1:0]  op_n = '0;
    logic [31:0] addr_n = '0, mem_n = '0, reg_n = '0;
    logic [31:0] res_n, aal_n;
    logic        err_n;
    // wide instance
    logic [1:0]  op_w = '0;
    logic [63:0] addr_w = '0, mem_w = '0, reg_w = '0;
    logic [63:0] res_w, aal_w;
    logic        err_w;

    uwm_merge_unit #(.WIDE(1'b0), .ADDR_W(32)) dut_i (
        .op_i(op_n), .addr_i(addr_n), .mem_word_i(mem_n), .reg_word_i(reg_n),
        .merged_o(res_n), .aligned_addr_o(aal_n), .addr_err_o(err_n));

    uwm_merge_unit #(.WIDE(1'b1), .ADDR_W(64)) dut_w (
        .op_i(op_w), .addr_i(addr_w), .mem_word_i(mem_w), .reg_word_i(reg_w),
        .merged_o(res_w), .aligned_addr_o(aal_w), .addr_err_o(err_w));

    function automatic logic [63:0] model(input int nb, input logic [1:0] op, input int off,
                                          input logic [63:0] mem, input logic [63:0] rg);
        logic [63:0] ones, r, m, g;
        int sh;
        ones = (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        m = mem & ones;
        g = rg & ones;
        sh = op[0] ? off * 8 : (nb - 1 - off) * 8;
        case (op)
            2'b00:   r = (m << sh) | (g & ~(ones << sh));
            2'b01:   r = (m >> sh) | (g & ~(ones >> sh));
            2'b10:   r = (g >> sh) | (m & ~(ones >> sh));
            default: r = (g << sh) | (m & ~(ones << sh));
        endcase
        return r & ones;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_n(input logic [1:0] op, input logic [31:0] a,
                           input logic [31:0] m, input logic [31:0] r);
        @(posedge clk);
        #1;
        op_n = op; addr_n = a; mem_n = m; reg_n = r;
        @(negedge clk);
    endtask

    task automatic drive_w(input logic [1:0] op, input logic [63:0] a,
                           input logic [63:0] m, input logic [63:0] r);
        @(posedge clk);
        #1;
        op_w = op; addr_w = a; mem_w = m; reg_w = r;
        @(negedge clk);
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rn, mn, an;
        logic [63:0] rw, mw, aw;
        void'($urandom(32'd20417));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero inputs give zero outputs
        check("R4 reset merged", 64'(res_n), 64'h0);
        check("R3 reset err", 64'(err_n), 64'h0);
        rst = 1'b0;

        // R1/R8/R9 directed, narrow, mem=11223344 reg=AABBCCDD
        drive_n(2'b01, 32'h100, 32'h11223344, 32'hAABBCCDD);
        check("R8 ld-right off0", 64'(res_n), 64'h11223344);
        drive_n(2'b00, 32'h100, 32'h11223344, 32'hAABBCCDD);
        check("R8 ld-left off0", 64'(res_n), 64'h44BBCCDD);
        drive_n(2'b00, 32'h103, 32'h11223344, 32'hAABBCCDD);
        check("R9 ld-left off3", 64'(res_n), 64'h11223344);
        drive_n(2'b11, 32'h100, 32'h11223344, 32'hAABBCCDD);
        check("R9 st-right off0", 64'(res_n), 64'hAABBCCDD);
        drive_n(2'b10, 32'h103, 32'h11223344, 32'hAABBCCDD);
        check("R9 st-left off3", 64'(res_n), 64'hAABBCCDD);
        drive_n(2'b00, 32'h101, 32'h11223344, 32'hAABBCCDD);
        check("R1 code 00 ld-left off1", 64'(res_n), 64'h3344CCDD);
        drive_n(2'b01, 32'h102, 32'h11223344, 32'hAABBCCDD);
        check("R1 code 01 ld-right off2", 64'(res_n), 64'hAABB1122);
        drive_n(2'b10, 32'h101, 32'h11223344, 32'hAABBCCDD);
        check("R1 code 10 st-left off1", 64'(res_n), 64'h1122AABB);
        drive_n(2'b11, 32'h102, 32'h11223344, 32'hAABBCCDD);
        check("R1 code 11 st-right off2", 64'(res_n), 64'hCCDD3344);

        // R2/R3 address corners
        drive_n(2'b00, 32'h8000_0003, 32'h0, 32'h0);
        check("R2 aligned", 64'(aal_n), 64'h8000_0000);
        check("R3 err top bit", 64'(err_n), 64'h1);
        drive_n(2'b11, 32'h7FFF_FFFE, 32'h0, 32'h0);
        check("R2 aligned", 64'(aal_n), 64'h7FFF_FFFC);
        check("R3 no fault on misalign", 64'(err_n), 64'h0);

        // every op at every offset, narrow
        for (int op = 0; op < 4; op++) begin
            for (int off = 0; off < 4; off++) begin
                mn = $urandom; rn = $urandom;
                an = {1'b0, 29'($urandom), 2'(off)};
                drive_n(2'(op), an, mn, rn);
                check(op_req(2'(op)), 64'(res_n), model(4, 2'(op), off, 64'(mn), 64'(rn)));
            end
        end

        // wide directed, R10
        drive_w(2'b00, 64'h40, 64'h0102030405060708, 64'hA1A2A3A4A5A6A7A8);
        check("R10 wide ld-left off0", res_w, 64'h08A2A3A4A5A6A7A8);
        drive_w(2'b01, 64'h47, 64'h0102030405060708, 64'hA1A2A3A4A5A6A7A8);
        check("R10 wide ld-right off7", res_w, 64'hA1A2A3A4A5A6A701);
        drive_w(2'b01, 64'h8000_0000_0000_0005, 64'h0, 64'h0);
        check("R10 wide aligned", aal_w, 64'h8000_0000_0000_0000);
        check("R10 wide err", 64'(err_w), 64'h1);
        for (int op = 0; op < 4; op++) begin
            for (int off = 0; off < 8; off++) begin
                mw = {$urandom, $urandom}; rw = {$urandom, $urandom};
                aw = {1'b0, 60'({$urandom, $urandom}), 3'(off)};
                drive_w(2'(op), aw, mw, rw);
                check("R10", res_w, model(8, 2'(op), off, mw, rw));
            end
        end

        // random sweep on both
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            op = 2'($urandom);
            mn = $urandom; rn = $urandom; an = $urandom;
            drive_n(op, an, mn, rn);
            check(op_req(op), 64'(res_n), model(4, op, int'(an[1:0]), 64'(mn), 64'(rn)));
            check("R2 random", 64'(aal_n), 64'({an[31:2], 2'b00}));
            check("R3 random", 64'(err_n), 64'(an[31]));
            mw = {$urandom, $urandom}; rw = {$urandom, $urandom}; aw = {$urandom, $urandom};
            drive_w(op, aw, mw, rw);
            check("R10 random", res_w, model(8, op, int'(aw[2:0]), mw, rw));
            check("R10 random addr", aal_w, {aw[63:3], 3'b000});
        end
        finish_run();
    end
endmodule